// File: doc/BRIEF.md
# Card Command Issue and Response Capture Unit

This unit sits between the register front end of a memory-card host controller and a card-side command engine. Software writes a 32-bit argument as two 16-bit halves, then writes a 16-bit command word. If the controller is enabled and no earlier command is still waiting for its response, the unit latches the word and clears its response store. It then sends a one-cycle request carrying the command index and argument to the card engine. An initialization command with index 0 is the exception: it completes locally and no request is sent.

The card engine answers with a byte-level response, up to 16 bytes wide, a byte count and a flag that marks a missing response. The unit checks the response length against the response type in the command word and works out completion, timeout, card-busy and card-error outcomes. It reports them as one-cycle status set pulses and loads the response bytes into eight 16-bit response registers, in reversed word order. Addressed data commands also start the data phase: they pulse a FIFO clear, latch the transfer direction and mark a transfer active. Any other command marks the transfer inactive.

Top module: `cmd_resp_unit`

## Requirements
- R1: The command word fields are: bits 5:0 the command index, bit 7 init, bits 10:8 the response type, bit 11 busy, bits 13:12 the command type and bit 15 the direction. The index of an accepted command appears on `card_idx` together with `card_req`.
- R2: A command write is ignored while `ctrl_en` is low. No request, no status pulse and no change to the response registers or the transfer state follow.
- R3: An accepted command clears all eight response registers in the cycle after the write.
- R4: An accepted command with init set and index 0 raises no request and no pending state. It produces a status pulse with only bit 0 set.
- R5: Response type 2 needs 16 bytes. Types 1, 3 and 6 need 4 bytes. If fewer bytes arrive, or the no-response flag is set, the status pulse is exactly bit 7 (timeout) and the response registers stay cleared.
- R6: On a valid typed response, bytes 2k (upper half) and 2k+1 (lower half) are joined into one word and stored in response register 7-k. Register j is `rsp_regs[16j+15:16j]`, and byte i is `rsp_bytes[8i+7:8i]`.
- R7: Type 1 responses, with or without busy, take bytes 0..3 as a big-endian 32-bit card status. Any of bits 31..26, 24..19 or 16 set raises status bit 14. Type 6 responses raise bit 14 only for bits 15:13 of that status.
- R8: A type 3 response whose status bit 31 is clear raises status bit 12.
- R9: A completed command with index 12 raises status bits 0 and 2. Any other completed command raises bit 0 alone, plus any bits from R7 and R8.
- R10: An accepted command of command type 3 pulses `fifo_clr`, sets `xfer_active` and latches `xfer_dir` from bit 15. Any other accepted command clears `xfer_active`.
- R11: A write to either argument half changes only that half of `card_arg`.
- R12: While a response is pending (`cmd_busy` high), new command writes are ignored. A response indication while nothing is pending produces no status and no register change.
- R13: Response types 0, 4, 5 and 7 complete on the response indication with bit 0 (or bits 0 and 2 for index 12), whatever the flag and length. The response registers stay cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable level |
| arg_lo_we | input | 1 | Write strobe, argument bits 15:0 |
| arg_hi_we | input | 1 | Write strobe, argument bits 31:16 |
| arg_wdata | input | 16 | Argument half data |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 16 | Command word |
| rsp_valid | input | 1 | Card engine response indication |
| rsp_none | input | 1 | No response received |
| rsp_len | input | 5 | Response byte count |
| rsp_bytes | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| card_req | output | 1 | One-cycle command request |
| card_idx | output | 6 | Command index of the latched command |
| card_arg | output | 32 | Current argument |
| cmd_busy | output | 1 | Response pending |
| stat_set | output | 16 | One-cycle status set pulses |
| rsp_regs | output | 128 | Eight response registers, register j at bits 16j+15:16j |
| xfer_active | output | 1 | Data transfer phase active |
| xfer_dir | output | 1 | Latched transfer direction |
| fifo_clr | output | 1 | One-cycle FIFO pointer reset |

## Verification
Every result here is registered exactly once. The request, the register clear, the transfer state, the argument update and the status pulse for a response all appear after the first rising edge that samples the write or response strobe, and never later. The bench drives each strobe for one cycle on a falling edge and samples all outputs at the next falling edge. That is the only cycle in which the single-cycle pulses can be seen, and it also confirms that nothing arrives a cycle late. State that should stay unchanged (pending flag, registers, transfer state) is sampled again in the same cycle after each ignored write or stray response.

// File: rtl/cmd_resp_pkg.sv
package cmd_resp_pkg;

    typedef struct packed {
        logic       dir;
        logic       rsvd14;
        logic [1:0] ctype;
        logic       busy;
        logic [2:0] rtype;
        logic       init;
        logic       rsvd6;
        logic [5:0] idx;
    } cmd_word_t;

    typedef enum logic [2:0] {
        RK_NONE  = 3'd0,
        RK_SHORT = 3'd1,
        RK_LONG  = 3'd2,
        RK_OCR   = 3'd3,
        RK_RCA   = 3'd4
    } rsp_kind_e;

    localparam logic [1:0] CT_DATA = 2'd3;

    localparam int ST_DONE    = 0;
    localparam int ST_STOP    = 2;
    localparam int ST_TIMEOUT = 7;
    localparam int ST_CBUSY   = 12;
    localparam int ST_CERR    = 14;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmd_resp_pkg::*;
(
    input  logic [15:0] word,
    output rsp_kind_e   kind,
    output logic [5:0]  idx,
    output logic        init_zero,
    output logic        data_cmd,
    output logic        dir
);
    cmd_word_t f;

    always_comb begin
        f         = cmd_word_t'(word);
        idx       = f.idx;
        init_zero = f.init && (f.idx == 6'd0);
        data_cmd  = (f.ctype == CT_DATA);
        dir       = f.dir;
        case (f.rtype)
            3'd1:    kind = RK_SHORT;   // busy flag promotes to 1b, same checks
            3'd2:    kind = RK_LONG;
            3'd3:    kind = RK_OCR;
            3'd6:    kind = RK_RCA;
            default: kind = RK_NONE;
        endcase
    end

endmodule

// File: rtl/rsp_classify.sv
module rsp_classify
    import cmd_resp_pkg::*;
#(
    parameter int          RSP_BYTES     = 16,
    parameter int          SHORT_BYTES   = 4,
    parameter int          STOP_IDX      = 12,
    parameter logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000,
    parameter logic [15:0] RCA_ERR_MASK  = 16'hE000,
    localparam int         LEN_W         = $clog2(RSP_BYTES + 1)
) (
    input  rsp_kind_e              kind,
    input  logic [5:0]             idx,
    input  logic                   none,
    input  logic [LEN_W-1:0]       len,
    input  logic [8*RSP_BYTES-1:0] bytes,
    output logic [15:0]            stat,
    output logic                   store
);
    localparam logic [LEN_W-1:0] LONG_NEED  = LEN_W'(RSP_BYTES);
    localparam logic [LEN_W-1:0] SHORT_NEED = LEN_W'(SHORT_BYTES);

    logic [LEN_W-1:0] got;
    logic [LEN_W-1:0] need;
    logic             timeout;
    logic [31:0]      card_st;

    always_comb begin
        got     = none ? '0 : len;
        card_st = {bytes[7:0], bytes[15:8], bytes[23:16], bytes[31:24]};
        case (kind)
            RK_NONE: need = '0;
            RK_LONG: need = LONG_NEED;
            default: need = SHORT_NEED;
        endcase
        timeout = (kind != RK_NONE) && (got < need);
        stat    = '0;
        store   = 1'b0;
        if (timeout) begin
            stat[ST_TIMEOUT] = 1'b1;
        end else begin
            stat[ST_DONE] = 1'b1;
            if (idx == 6'(STOP_IDX))
                stat[ST_STOP] = 1'b1;
            store = (kind != RK_NONE);
            case (kind)
                RK_SHORT: stat[ST_CERR]  = |(card_st & CARD_ERR_MASK);
                RK_RCA:   stat[ST_CERR]  = |(card_st[15:0] & RCA_ERR_MASK);
                RK_OCR:   stat[ST_CBUSY] = ~card_st[31];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/rsp_bank.sv
module rsp_bank #(
    parameter  int RSP_WORDS = 8,
    localparam int RSP_BYTES = 2 * RSP_WORDS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic [8*RSP_BYTES-1:0]  bytes,
    output logic [16*RSP_WORDS-1:0] regs
);
    logic [16*RSP_WORDS-1:0] regs_d, regs_q;

    // Register g takes the pair starting at byte 2*(RSP_WORDS-1-g), even byte high.
    for (genvar g = 0; g < RSP_WORDS; g++) begin : g_word
        localparam int K = RSP_WORDS - 1 - g;
        always_comb begin
            regs_d[16*g +: 16] = regs_q[16*g +: 16];
            if (clr)
                regs_d[16*g +: 16] = '0;
            else if (load)
                regs_d[16*g +: 16] = {bytes[8*(2*K) +: 8], bytes[8*(2*K+1) +: 8]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    assert_clr_load_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && load));

endmodule

// File: rtl/cmd_resp_unit.sv
module cmd_resp_unit
    import cmd_resp_pkg::*;
#(
    parameter  int          RSP_WORDS     = 8,
    parameter  int          STOP_IDX      = 12,
    parameter  logic [31:0] CARD_ERR_MASK = 32'hFDF9_0000,
    localparam int          RSP_BYTES     = 2 * RSP_WORDS,
    localparam int          LEN_W         = $clog2(RSP_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctrl_en,
    input  logic                    arg_lo_we,
    input  logic                    arg_hi_we,
    input  logic [15:0]             arg_wdata,
    input  logic                    cmd_we,
    input  logic [15:0]             cmd_wdata,
    input  logic                    rsp_valid,
    input  logic                    rsp_none,
    input  logic [LEN_W-1:0]        rsp_len,
    input  logic [8*RSP_BYTES-1:0]  rsp_bytes,
    output logic                    card_req,
    output logic [5:0]              card_idx,
    output logic [31:0]             card_arg,
    output logic                    cmd_busy,
    output logic [15:0]             stat_set,
    output logic [16*RSP_WORDS-1:0] rsp_regs,
    output logic                    xfer_active,
    output logic                    xfer_dir,
    output logic                    fifo_clr
);
    typedef struct packed {
        logic        pending;
        logic [15:0] last_cmd;
        logic [31:0] arg;
        logic        act;
        logic        dir;
        logic        req;
        logic        clr;
        logic [15:0] stat;
    } ctl_t;

    ctl_t s_d, s_q;

    rsp_kind_e   in_kind, cur_kind;
    logic [5:0]  in_idx, cur_idx;
    logic        in_init0, in_data, in_dir;
    logic        cur_init0, cur_data, cur_dir;
    logic [15:0] cls_stat;
    logic        cls_store;
    logic        bank_clr, bank_load;
    logic        accept;

    cmd_decode u_dec_in (
        .word(cmd_wdata), .kind(in_kind), .idx(in_idx),
        .init_zero(in_init0), .data_cmd(in_data), .dir(in_dir)
    );

    cmd_decode u_dec_cur (
        .word(s_q.last_cmd), .kind(cur_kind), .idx(cur_idx),
        .init_zero(cur_init0), .data_cmd(cur_data), .dir(cur_dir)
    );

    rsp_classify #(
        .RSP_BYTES(RSP_BYTES), .STOP_IDX(STOP_IDX), .CARD_ERR_MASK(CARD_ERR_MASK)
    ) u_cls (
        .kind(cur_kind), .idx(cur_idx), .none(rsp_none), .len(rsp_len),
        .bytes(rsp_bytes), .stat(cls_stat), .store(cls_store)
    );

    rsp_bank #(.RSP_WORDS(RSP_WORDS)) u_bank (
        .clk(clk), .rst_n(rst_n), .clr(bank_clr), .load(bank_load),
        .bytes(rsp_bytes), .regs(rsp_regs)
    );

    always_comb begin
        s_d       = s_q;
        s_d.req   = 1'b0;
        s_d.clr   = 1'b0;
        s_d.stat  = '0;
        bank_clr  = 1'b0;
        bank_load = 1'b0;
        accept    = cmd_we && ctrl_en && !s_q.pending;

        if (arg_lo_we) s_d.arg[15:0]  = arg_wdata;
        if (arg_hi_we) s_d.arg[31:16] = arg_wdata;

        if (accept) begin
            s_d.last_cmd = cmd_wdata;
            bank_clr     = 1'b1;
            if (in_init0) begin
                s_d.stat[ST_DONE] = 1'b1;
            end else begin
                s_d.req     = 1'b1;
                s_d.pending = 1'b1;
                s_d.act     = in_data;
                if (in_data) begin
                    s_d.clr = 1'b1;
                    s_d.dir = in_dir;
                end
            end
        end else if (rsp_valid && s_q.pending) begin
            s_d.pending = 1'b0;
            s_d.stat    = cls_stat;
            bank_load   = cls_store;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign card_req    = s_q.req;
    assign card_idx    = s_q.last_cmd[5:0];
    assign card_arg    = s_q.arg;
    assign cmd_busy    = s_q.pending;
    assign stat_set    = s_q.stat;
    assign xfer_active = s_q.act;
    assign xfer_dir    = s_q.dir;
    assign fifo_clr    = s_q.clr;

    assert_req_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> $past(cmd_we && ctrl_en));

    assert_regs_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        card_req |-> (rsp_regs == '0));

    assert_status_needs_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cmd_busy) && !$past(cmd_we)) |-> (stat_set == '0));

    assert_timeout_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set[ST_TIMEOUT] |-> (stat_set == 16'h0080));

    assert_stop_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_set[ST_STOP] |-> stat_set[ST_DONE]);

    assert_init_no_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set != '0) |-> !card_req);

    assert_clr_with_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> (card_req && xfer_active));

endmodule

// File: tb/cmd_resp_unit_bench.sv
`timescale 1ns/1ps
module cmd_resp_unit_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_en = 1'b0;
    logic         arg_lo_we = 1'b0, arg_hi_we = 1'b0;
    logic [15:0]  arg_wdata = '0;
    logic         cmd_we = 1'b0;
    logic [15:0]  cmd_wdata = '0;
    logic         rsp_valid = 1'b0, rsp_none = 1'b0;
    logic [4:0]   rsp_len = '0;
    logic [127:0] rsp_bytes = '0;
    logic         card_req, cmd_busy, xfer_active, xfer_dir, fifo_clr;
    logic [5:0]   card_idx;
    logic [31:0]  card_arg;
    logic [15:0]  stat_set;
    logic [127:0] rsp_regs;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [127:0] m_regs = '0;
    logic [31:0]  m_arg = '0;
    logic [15:0]  m_cmd = '0;
    logic         m_pend = 1'b0, m_act = 1'b0, m_dir = 1'b0;

    always #4 clk = ~clk;

    cmd_resp_unit u_cmd_resp_unit (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .arg_lo_we(arg_lo_we), .arg_hi_we(arg_hi_we), .arg_wdata(arg_wdata),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_none(rsp_none), .rsp_len(rsp_len), .rsp_bytes(rsp_bytes),
        .card_req(card_req), .card_idx(card_idx), .card_arg(card_arg), .cmd_busy(cmd_busy),
        .stat_set(stat_set), .rsp_regs(rsp_regs), .xfer_active(xfer_active),
        .xfer_dir(xfer_dir), .fifo_clr(fifo_clr)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int need_bytes(input logic [2:0] rt);
        case (rt)
            3'd2:             return 16;
            3'd1, 3'd3, 3'd6: return 4;
            default:          return 0;
        endcase
    endfunction

    function automatic logic [15:0] exp_stat(input logic [15:0] w, input logic none,
                                             input logic [4:0] len, input logic [127:0] b);
        logic [15:0] s;
        logic [31:0] cs;
        int got, nd;
        nd  = need_bytes(w[10:8]);
        got = none ? 0 : int'(len);
        cs  = {b[7:0], b[15:8], b[23:16], b[31:24]};
        if (nd > 0 && got < nd) return 16'h0080;
        s = (w[5:0] == 6'd12) ? 16'h0005 : 16'h0001;
        if (w[10:8] == 3'd1 && (cs & 32'hFDF9_0000) != 0) s |= 16'h4000;
        if (w[10:8] == 3'd6 && cs[15:13] != 0)            s |= 16'h4000;
        if (w[10:8] == 3'd3 && !cs[31])                   s |= 16'h1000;
        return s;
    endfunction

    function automatic bit exp_store(input logic [15:0] w, input logic none, input logic [4:0] len);
        int nd = need_bytes(w[10:8]);
        return nd > 0 && !none && int'(len) >= nd;
    endfunction

    function automatic logic [127:0] pack_regs(input logic [127:0] b);
        logic [127:0] r;
        for (int k = 0; k < 8; k++)
            r[16*(7-k) +: 16] = {b[8*(2*k) +: 8], b[8*(2*k+1) +: 8]};
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_arg(input bit lo, input bit hi, input logic [15:0] d);
        arg_lo_we = lo; arg_hi_we = hi; arg_wdata = d;
        step();
        arg_lo_we = 1'b0; arg_hi_we = 1'b0;
        if (lo) m_arg[15:0]  = d;
        if (hi) m_arg[31:16] = d;
        chk(card_arg == m_arg, "R11 argument half", 128'(card_arg), 128'(m_arg));
    endtask

    task automatic issue(input logic [15:0] w, input logic en);
        bit acc, i0;
        logic [15:0] es;
        acc = en && !m_pend;
        i0  = w[7] && (w[5:0] == 6'd0);
        ctrl_en = en; cmd_wdata = w; cmd_we = 1'b1;
        step();
        cmd_we = 1'b0;
        es = '0;
        if (acc) begin
            m_cmd  = w;
            m_regs = '0;
            if (i0) es = 16'h0001;
            else begin
                m_pend = 1'b1;
                m_act  = (w[13:12] == 2'd3);
                if (m_act) m_dir = w[15];
            end
        end
        if (!en)
            chk(card_req == 1'b0 && stat_set == 16'h0, "R2 disabled write ignored",
                128'({card_req, stat_set}), 128'(0));
        else if (!acc)
            chk(card_req == 1'b0 && stat_set == 16'h0, "R12 write while pending ignored",
                128'({card_req, stat_set}), 128'(0));
        else if (i0)
            chk(card_req == 1'b0 && stat_set == es && cmd_busy == 1'b0, "R4 init index 0",
                128'({card_req, cmd_busy, stat_set}), 128'(es));
        else begin
            chk(card_req == 1'b1 && stat_set == 16'h0, "R1 request raised", 128'({card_req, stat_set}), 128'(17'h10000));
            chk(card_idx == w[5:0], "R1 command index", 128'(card_idx), 128'(w[5:0]));
            chk(fifo_clr == m_act, "R10 fifo clear pulse", 128'(fifo_clr), 128'(m_act));
        end
        chk(rsp_regs == m_regs, "R3 response registers after write", rsp_regs, m_regs);
        chk(cmd_busy == m_pend, "R12 pending flag", 128'(cmd_busy), 128'(m_pend));
        chk(xfer_active == m_act && (!m_act || xfer_dir == m_dir), "R10 transfer state",
            128'({xfer_active, xfer_dir}), 128'({m_act, m_dir}));
    endtask

    task automatic respond(input logic none, input logic [4:0] len, input logic [127:0] b);
        logic [15:0] es;
        es = '0;
        rsp_valid = 1'b1; rsp_none = none; rsp_len = len; rsp_bytes = b;
        step();
        rsp_valid = 1'b0;
        if (m_pend) begin
            es = exp_stat(m_cmd, none, len, b);
            if (exp_store(m_cmd, none, len)) m_regs = pack_regs(b);
            m_pend = 1'b0;
        end
        if (es[7])
            chk(stat_set == es, "R5 timeout status", 128'(stat_set), 128'(es));
        else if (need_bytes(m_cmd[10:8]) == 0)
            chk(stat_set == es, "R13 no-response type status", 128'(stat_set), 128'(es));
        else
            chk(stat_set == es, "R7 R8 R9 completion status", 128'(stat_set), 128'(es));
        chk(rsp_regs == m_regs, "R6 response register contents", rsp_regs, m_regs);
        chk(cmd_busy == 1'b0, "R12 pending cleared", 128'(cmd_busy), 128'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] b;
        logic [15:0]  w;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(card_req == 0 && cmd_busy == 0 && stat_set == 0 && rsp_regs == 0 && card_arg == 0 &&
            xfer_active == 0, "R2 reset state", 128'({card_req, cmd_busy, stat_set, card_arg}), 128'(0));

        // Directed corners
        write_arg(1, 0, 16'hBEEF);
        write_arg(0, 1, 16'hDEAD);                       // R11
        issue(16'h0080, 1'b1);                           // R4 init, index 0
        issue(16'h0111, 1'b0);                           // R2 disabled
        respond(1'b0, 5'd4, 128'h1);                     // R12 stray response
        b = 128'h0f0e0d0c0b0a09080706050403020100;
        issue(16'h0202, 1'b1);                           // type 2
        issue(16'h0203, 1'b1);                           // R12 blocked
        respond(1'b0, 5'd16, b);                         // R6 ordering
        chk(rsp_regs[127:112] == 16'h0001 && rsp_regs[15:0] == 16'h0e0f, "R6 word order",
            rsp_regs, pack_regs(b));
        issue(16'h0202, 1'b1);                           // R3 clears
        respond(1'b0, 5'd15, b);                         // R5 short long response
        issue(16'h010C, 1'b1);                           // R9 index 12, type 1
        respond(1'b0, 5'd4, 128'h0);
        issue(16'h0111, 1'b1);
        respond(1'b0, 5'd4, 128'h00000080);              // R7 card error bit 31
        issue(16'h0626, 1'b1);
        respond(1'b0, 5'd4, 128'h00200000);              // R7 type 6 bit 13
        issue(16'h0329, 1'b1);
        respond(1'b0, 5'd4, 128'h00000000);              // R8 busy
        issue(16'hB112, 1'b1);                           // R10 data read
        respond(1'b1, 5'd0, b);                          // R5 no response flag
        issue(16'h0007, 1'b1);                           // R10 other type clears
        respond(1'b1, 5'd0, b);                          // R13

        // Random mix
        for (int it = 0; it < 150; it++) begin
            if ($urandom % 3 == 0) write_arg($urandom % 2 == 0, $urandom % 2 == 0, 16'($urandom));
            w = 16'($urandom);
            case ($urandom % 8)
                0: w[7:0] = 8'h80;
                1: w[5:0] = 6'd12;
                default: ;
            endcase
            issue(w, ($urandom % 8) != 0);
            if (m_pend && $urandom % 4 == 0) issue(16'($urandom), 1'b1);
            if (!m_pend && $urandom % 4 == 0) respond(1'b0, 5'd16, {4{$urandom}});
            if (m_pend) begin
                b = {$urandom, $urandom, $urandom, $urandom};
                if ($urandom % 2 == 0) b[15:0] = '0;
                case ($urandom % 5)
                    0: respond(1'b0, 5'd3, b);
                    1: respond(1'b0, 5'd15, b);
                    2: respond(1'b1, 5'd16, b);
                    default: respond(1'b0, ($urandom % 2 == 0) ? 5'd4 : 5'd16, b);
                endcase
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule